// File: doc/BRIEF.md
# Funnel Shifter with Rotate

This block is a purely combinational shifter for one W-bit word. It places two W-bit words side by side to form a 2W-bit field, with an upper word on the left and a lower word on the right. It then takes W consecutive bits out of that field, starting at a bit offset. A cascade of log2(W) levels of 2:1 multiplexers does the extraction. Level s moves the field right by 2^s positions when bit s of the offset is set.

The operation code does not drive four separate shifters. It only selects which values go into the upper word, the lower word and the offset. As a result, one extraction network performs logical right shift, arithmetic right shift, rotate right and logical left shift. A datapath uses it by presenting an operand, an amount and a code. The result is ready in the same cycle.

Top module: `funnel_rot_shifter`

## Requirements
- R1: The 2-bit code `op_i` selects the operation: 0 = logical right, 1 = arithmetic right, 2 = rotate right, 3 = logical left. For code 0, the result equals the operand shifted right by `shamt_i`, and the top `shamt_i` result bits are 0.
- R2: For code 1, the result equals the operand shifted right by `shamt_i`, and the top `shamt_i` result bits equal bit W-1 of the operand.
- R3: For code 2, result bit k equals operand bit (k + `shamt_i`) mod W. The number of set bits in the result therefore equals that of the operand.
- R4: For code 3, the result equals the operand shifted left by `shamt_i`, and the low `shamt_i` result bits are 0.
- R5: An amount of 0 returns the operand unchanged for every code.
- R6: The largest amount, W-1, is handled in one operation by every code. For example, a logical right shift by W-1 leaves the operand MSB in bit 0 and zeros above it.
- R7: The block holds no state. The result follows a change of any input without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | W (32) | Operand word |
| shamt_i | input | log2(W) (5) | Shift or rotate amount, 0 to W-1 |
| op_i | input | 2 | Operation code: 0 logical right, 1 arithmetic right, 2 rotate right, 3 logical left |
| result_o | output | W (32) | Shifted or rotated word |

## Verification
The assertions assume that every input is driven to a known 0/1 value. They also assume that `shamt_i` is read as an unsigned count below W, which its width already guarantees. Under these assumptions the fill-bit, bit-count and identity properties follow from the inputs alone. The stimulus never leaves inputs undriven. It steps the amount through every value from 0 to W-1 for each code. Inputs change only on the falling clock edge, so the checks always see settled values.

// File: rtl/funnel_shift_pkg.sv
package funnel_shift_pkg;
    typedef enum logic [1:0] {
        SH_SRL = 2'd0,
        SH_SRA = 2'd1,
        SH_ROR = 2'd2,
        SH_SLL = 2'd3
    } shift_op_e;
endpackage

// File: rtl/funnel_word_select.sv
module funnel_word_select
    import funnel_shift_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    input  logic [AW-1:0] amount,
    input  shift_op_e     op,
    output logic [W-1:0]  upper,
    output logic [W-1:0]  lower,
    output logic [AW-1:0] offset
);
    localparam logic [AW-1:0] ZERO_AMT = '0;

    always_comb begin
        unique case (op)
            SH_SRL: begin
                upper  = '0;
                lower  = opnd;
                offset = amount;
            end
            SH_SRA: begin
                upper  = {W{opnd[W-1]}};
                lower  = opnd;
                offset = amount;
            end
            SH_ROR: begin
                upper  = opnd;
                lower  = opnd;
                offset = amount;
            end
            SH_SLL: begin
                // offset W-i modulo W; for i=0 the lower word carries the operand
                upper  = opnd;
                lower  = (amount == ZERO_AMT) ? opnd : '0;
                offset = ZERO_AMT - amount;
            end
            default: begin
                upper  = '0;
                lower  = opnd;
                offset = amount;
            end
        endcase
    end
endmodule

// File: rtl/funnel_extract.sv
module funnel_extract #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  upper,
    input  logic [W-1:0]  lower,
    input  logic [AW-1:0] offset,
    output logic [W-1:0]  window
);
    localparam int FW = 2 * W;

    logic [FW-1:0] level [0:AW];

    assign level[0] = {upper, lower};

    genvar s;
    generate
        for (s = 0; s < AW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign level[s+1] = offset[s] ? {{STEP{1'b0}}, level[s][FW-1:STEP]}
                                          : level[s];
        end
    endgenerate

    assign window = level[AW][W-1:0];
endmodule

// File: rtl/funnel_rot_shifter.sv
module funnel_rot_shifter
    import funnel_shift_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [AW-1:0] shamt_i,
    input  logic [1:0]    op_i,
    output logic [W-1:0]  result_o
);
    shift_op_e     op_sel;
    logic [W-1:0]  up_word;
    logic [W-1:0]  lo_word;
    logic [AW-1:0] ext_ofs;

    assign op_sel = shift_op_e'(op_i);

    funnel_word_select #(.W(W), .AW(AW)) u_select (
        .opnd   (opnd_i),
        .amount (shamt_i),
        .op     (op_sel),
        .upper  (up_word),
        .lower  (lo_word),
        .offset (ext_ofs)
    );

    funnel_extract #(.W(W), .AW(AW)) u_extract (
        .upper  (up_word),
        .lower  (lo_word),
        .offset (ext_ofs),
        .window (result_o)
    );
endmodule

// File: rtl/funnel_rot_shifter_chk.sv
module funnel_rot_shifter_chk #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input logic [W-1:0]  opnd_i,
    input logic [AW-1:0] shamt_i,
    input logic [1:0]    op_i,
    input logic [W-1:0]  result_o
);
    logic srl_fill_ok;
    logic sra_fill_ok;
    logic sll_fill_ok;

    always_comb begin
        srl_fill_ok = 1'b1;
        sra_fill_ok = 1'b1;
        sll_fill_ok = 1'b1;
        for (int k = 0; k < W; k++) begin
            if (k >= W - int'(shamt_i)) begin
                if (result_o[k] != 1'b0)         srl_fill_ok = 1'b0;
                if (result_o[k] != opnd_i[W-1])  sra_fill_ok = 1'b0;
            end
            if (k < int'(shamt_i)) begin
                if (result_o[k] != 1'b0)         sll_fill_ok = 1'b0;
            end
        end
    end

    always_comb begin
        if (op_i == 2'd0) begin
            assert_srl_zero_fill_R1: assert (srl_fill_ok);
        end
        if (op_i == 2'd1) begin
            assert_sra_sign_fill_R2: assert (sra_fill_ok);
        end
        if (op_i == 2'd2) begin
            assert_ror_keeps_ones_R3: assert ($countones(result_o) == $countones(opnd_i));
        end
        if (op_i == 2'd3) begin
            assert_sll_zero_fill_R4: assert (sll_fill_ok);
        end
        if (shamt_i == '0) begin
            assert_zero_amount_identity_R5: assert (result_o == opnd_i);
        end
    end
endmodule

bind funnel_rot_shifter funnel_rot_shifter_chk #(.W(W), .AW(AW)) u_chk (
    .opnd_i   (opnd_i),
    .shamt_i  (shamt_i),
    .op_i     (op_i),
    .result_o (result_o)
);

// File: tb/funnel_rot_shifter_bench.sv
`timescale 1ns/1ps
module funnel_rot_shifter_bench;
    localparam int W  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  opnd;
    logic [AW-1:0] shamt;
    logic [1:0]    op;
    logic [W-1:0]  res;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    funnel_rot_shifter u_funnel_rot_shifter (
        .opnd_i   (opnd),
        .shamt_i  (shamt),
        .op_i     (op),
        .result_o (res)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] x, input int a, input int code);
        logic [W-1:0] r;
        case (code)
            0: r = x >> a;
            1: r = W'($signed(x) >>> a);
            2: r = (a == 0) ? x : ((x >> a) | (x << (W - a)));
            default: r = x << a;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] expv);
        n_tests++;
        if (res !== expv) begin
            n_fail++;
            $display("FAIL %s op=%0d amt=%0d opnd=%h actual=%h expected=%h",
                     tag, op, shamt, opnd, res, expv);
        end
    endtask

    initial begin
        logic [W-1:0] pats [10];
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000;
        pats[3] = 32'h0000_0001;
        pats[4] = 32'h8421_F00D;
        pats[5] = 32'h7FFF_FFFE;
        for (int p = 6; p < 10; p++) pats[p] = $urandom;

        opnd = '0; shamt = '0; op = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("reset-state R1", '0);
        @(negedge clk) rst = 1'b0;

        for (int p = 0; p < 10; p++) begin
            for (int c = 0; c < 4; c++) begin
                for (int a = 0; a < W; a++) begin
                    string tag;
                    @(negedge clk);
                    opnd  = pats[p];
                    op    = 2'(c);
                    shamt = AW'(a);
                    @(posedge clk);
                    #1;
                    if (a == 0)          tag = "R5";
                    else if (a == W - 1) tag = "R6";
                    else if (c == 0)     tag = "R1";
                    else if (c == 1)     tag = "R2";
                    else if (c == 2)     tag = "R3";
                    else                 tag = "R4";
                    check(tag, model(pats[p], a, c));
                end
            end
        end

        // R7: no clock edge between input change and sampling
        @(negedge clk);
        opnd = 32'hC000_0003; op = 2'd2; shamt = 5'd1;
        #0.5;
        check("R7", 32'hE000_0001);
        opnd = 32'h0000_00F0; op = 2'd3; shamt = 5'd4;
        #0.5;
        check("R7", 32'h0000_0F00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule